// File: doc/BRIEF.md
# Transmit Squelch Gate with End-of-Packet Detection

This block performs the digital gating of a 10 Mb/s Manchester transmit path. Three inputs come in, each sampled on the block clock: a comparator flag that reports an excursion beyond the squelch threshold, the transmit data bit, and a level that says whether the DC squelch condition still holds. The path stays closed until the excursion flag has been present long enough to rule out noise. Once the path is open, data passes through to the line driver. The path closes in one of two ways. The first is an idle end-of-packet, where data stays high for longer than the idle limit. The second is a loss of the DC squelch condition.

After an idle end-of-packet the block enters a rejection window of fixed length. During that window every input is ignored, so that trailing dribble bits never reach the cable. Whenever the path is not open, the data output sits at its idle level of logic 1.

Each duration is set in nanoseconds and converted to sample cycles by rounding up. With the default 100 MHz clock, the durations come to 2 cycles for qualification, 18 cycles for the idle limit and 80 cycles for the window.

Top module: `tx_squelch_gate`

## Requirements
- R1: While `rst_n` is low, `tx_en_o` is 0 and `tx_data_o` is 1.
- R2: A run of `sq_exceed_i` high shorter than QUAL_CYC consecutive samples does not open the path.
- R3: QUAL_CYC consecutive high samples of `sq_exceed_i` open the path. `tx_en_o` rises right after the clock edge that takes the last of those samples.
- R4: While `tx_en_o` is 1, `tx_data_o` equals `tx_data_i` in the same cycle.
- R5: While the path is open, IDL_CYC consecutive high samples of `tx_data_i` close it. `tx_en_o` falls after the edge that takes the last of those samples.
- R6: After an idle close, the path stays shut for REJ_CYC cycles whatever `sq_exceed_i` does. Only after that does a fresh qualification start, so with `sq_exceed_i` held high, `tx_en_o` returns REJ_CYC+QUAL_CYC cycles after the close.
- R7: A low sample of `dc_ok_i` while the path is open closes it at that edge, with no rejection window. A new qualification may start on the next cycle.
- R8: When the idle close and the DC loss fall on the same edge, the idle close takes priority and the rejection window is applied.
- R9: Whenever `tx_en_o` is 0, `tx_data_o` is 1.
- R10: The durations are ceil(ns*CLK_MHZ/1000) cycles, and qualification needs at least 2 cycles. A high run of IDL_CYC-1 samples leaves the path open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sq_exceed_i | input | 1 | Comparator flag: input beyond squelch threshold |
| tx_data_i | input | 1 | Sampled transmit data |
| dc_ok_i | input | 1 | DC squelch condition met |
| tx_en_o | output | 1 | Transmit path open |
| tx_data_o | output | 1 | Gated transmit data, 1 when the path is closed |

## Verification
The idle end-of-packet and the loss of the DC squelch condition can both close the path on the same clock edge. The bench provokes this by sending IDL_CYC-1 high data samples and then a final high sample with `dc_ok_i` low, while it holds the squelch flag high. It judges the result by when `tx_en_o` comes back. If the window was applied, `tx_en_o` stays low at the third sample and returns only after REJ_CYC+QUAL_CYC cycles. If the DC loss had won, the path would already be open again at the third sample.

// File: rtl/txsq_pkg.sv
package txsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUALIFY = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_REJECT  = 2'd3
  } txsq_state_e;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/txsq_ctr.sv
module txsq_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/txsq_fsm.sv
module txsq_fsm
  import txsq_pkg::*;
#(
  parameter int QUAL_CYC = 2,
  parameter int IDL_CYC  = 18,
  parameter int REJ_CYC  = 80,
  parameter int TW       = 7,
  parameter int HW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sq_exc,
  input  logic          dat,
  input  logic          dc_ok,
  input  logic [TW-1:0] tmr,
  input  logic [HW-1:0] hrun,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic          hrun_clr,
  output logic          hrun_inc,
  output logic          active
);
  localparam logic [TW-1:0] QUAL_LAST = TW'(QUAL_CYC - 2);
  localparam logic [TW-1:0] REJ_LAST  = TW'(REJ_CYC - 1);
  localparam logic [HW-1:0] IDL_LAST  = HW'(IDL_CYC - 1);

  txsq_state_e state, state_nxt;
  logic        idl_hit;

  assign idl_hit = dat && (hrun == IDL_LAST);

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:    if (sq_exc) state_nxt = ST_QUALIFY;
      ST_QUALIFY: begin
        if (!sq_exc)               state_nxt = ST_IDLE;
        else if (tmr == QUAL_LAST) state_nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (idl_hit)     state_nxt = ST_REJECT;
        else if (!dc_ok) state_nxt = ST_IDLE;
      end
      ST_REJECT:  if (tmr == REJ_LAST) state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_clr  = (state_nxt != state);
    tmr_inc  = !tmr_clr && (state != ST_IDLE);
    hrun_clr = !((state == ST_ACTIVE) && dat) || (state_nxt != ST_ACTIVE);
    hrun_inc = !hrun_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign active = (state == ST_ACTIVE);
endmodule

// File: rtl/txsq_outgate.sv
module txsq_outgate (
  input  logic active,
  input  logic dat,
  output logic en_o,
  output logic dat_o
);
  always_comb begin
    en_o  = active;
    dat_o = active ? dat : 1'b1;
  end
endmodule

// File: rtl/tx_squelch_gate.sv
module tx_squelch_gate
  import txsq_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int QUAL_NS = 17,
  parameter int IDL_NS  = 175,
  parameter int REJ_NS  = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_exceed_i,
  input  logic tx_data_i,
  input  logic dc_ok_i,
  output logic tx_en_o,
  output logic tx_data_o
);
  localparam int QUAL_RAW = ns_to_cyc(QUAL_NS, CLK_MHZ);
  localparam int QUAL_CYC = (QUAL_RAW < 2) ? 2 : QUAL_RAW;
  localparam int IDL_RAW  = ns_to_cyc(IDL_NS, CLK_MHZ);
  localparam int IDL_CYC  = (IDL_RAW < 1) ? 1 : IDL_RAW;
  localparam int REJ_RAW  = ns_to_cyc(REJ_NS, CLK_MHZ);
  localparam int REJ_CYC  = (REJ_RAW < 1) ? 1 : REJ_RAW;
  localparam int TMAX     = (QUAL_CYC > REJ_CYC) ? QUAL_CYC : REJ_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int HW       = $clog2(IDL_CYC + 1);

  logic [TW-1:0] tmr;
  logic [HW-1:0] hrun;
  logic          tmr_clr, tmr_inc, hrun_clr, hrun_inc, active;

  txsq_fsm #(
    .QUAL_CYC(QUAL_CYC), .IDL_CYC(IDL_CYC), .REJ_CYC(REJ_CYC), .TW(TW), .HW(HW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sq_exc(sq_exceed_i), .dat(tx_data_i), .dc_ok(dc_ok_i),
    .tmr(tmr), .hrun(hrun), .tmr_clr(tmr_clr), .tmr_inc(tmr_inc),
    .hrun_clr(hrun_clr), .hrun_inc(hrun_inc), .active(active)
  );

  txsq_ctr #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .cnt(tmr)
  );

  txsq_ctr #(.W(HW)) u_hrun (
    .clk(clk), .rst_n(rst_n), .clr(hrun_clr), .inc(hrun_inc), .cnt(hrun)
  );

  txsq_outgate u_gate (
    .active(active), .dat(tx_data_i), .en_o(tx_en_o), .dat_o(tx_data_o)
  );
endmodule

// File: rtl/txsq_chk.sv
module txsq_chk #(
  parameter int IDL_CYC = 18,
  parameter int REJ_CYC = 80
) (
  input logic clk,
  input logic rst_n,
  input logic sq_exceed_i,
  input logic tx_data_i,
  input logic dc_ok_i,
  input logic tx_en_o,
  input logic tx_data_o
);
  logic [15:0] hi_run;
  logic [15:0] win_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      win_left <= '0;
    end else begin
      if (tx_en_o && tx_data_i) hi_run <= hi_run + 16'd1;
      else                      hi_run <= '0;
      if (tx_en_o && tx_data_i && (hi_run == 16'(IDL_CYC - 1))) win_left <= 16'(REJ_CYC);
      else if (win_left != 16'd0)                                win_left <= win_left - 16'd1;
    end
  end

  AST_RESET_CLOSED: assert property (@(posedge clk) !rst_n |-> (!tx_en_o && tx_data_o)); // R1
  AST_OPEN_NEEDS_EXCEED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(sq_exceed_i)); // R3
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (tx_data_o == tx_data_i)); // R4
  AST_IDL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && tx_data_i && hi_run == 16'(IDL_CYC - 1)) |=> !tx_en_o); // R5
  AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_left != 16'd0) |-> !tx_en_o); // R6
  AST_DC_LOSS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && !dc_ok_i) |=> !tx_en_o); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_o |-> tx_data_o); // R9
endmodule

bind tx_squelch_gate txsq_chk #(.IDL_CYC(IDL_CYC), .REJ_CYC(REJ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sq_exceed_i(sq_exceed_i), .tx_data_i(tx_data_i),
  .dc_ok_i(dc_ok_i), .tx_en_o(tx_en_o), .tx_data_o(tx_data_o)
);

// File: tb/test_tx_squelch_gate.sv
module test_tx_squelch_gate;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = (17 * 100 + 999) / 1000;
  localparam int IDL  = (175 * 100 + 999) / 1000;
  localparam int REJ  = (800 * 100 + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc = 1'b0, dat = 1'b0, dc = 1'b1;
  logic en_o, dat_o;
  int tests = 0, fails = 0;
  int phase = 0, qrun = 0, hr = 0, win = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_squelch_gate i_tx_squelch_gate (
    .clk(clk), .rst_n(rst_n), .sq_exceed_i(exc), .tx_data_i(dat), .dc_ok_i(dc),
    .tx_en_o(en_o), .tx_data_o(dat_o)
  );

  // Behavioural reference: phase 0 closed, 1 open, 2 dribble window
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; qrun = 0; hr = 0; win = 0;
    end else begin
      case (phase)
        0: begin
          qrun = exc ? qrun + 1 : 0;
          if (qrun >= QUAL) begin phase = 1; hr = 0; qrun = 0; end
        end
        1: begin
          hr = dat ? hr + 1 : 0;
          if (hr >= IDL)  begin phase = 2; win = 0; end
          else if (!dc)   begin phase = 0; qrun = 0; end
        end
        default: begin
          win = win + 1;
          if (win >= REJ) begin phase = 0; qrun = 0; end
        end
      endcase
    end
  end

  task automatic check(input logic cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic d, input logic c);
    @(negedge clk);
    exc = e; dat = d; dc = c;
    #1;
    check(en_o == (phase == 1), "R3 enable vs model", int'(en_o), int'(phase == 1));
    check(dat_o == ((phase == 1) ? dat : 1'b1), "R4/R9 data vs model", int'(dat_o),
          int'((phase == 1) ? dat : 1'b1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3;
    check(en_o == 1'b0 && dat_o == 1'b1, "R1 reset state", int'({en_o, dat_o}), 1);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: rounded cycle counts
    check(QUAL == 2 && IDL == 18 && REJ == 80, "R10 rounding", QUAL * 10000 + IDL * 100 + REJ, 21880);

    // R2: short excursions are noise
    step(1, 0, 1); step(0, 0, 1); step(0, 0, 1);
    check(en_o == 1'b0, "R2 single-sample pulse", int'(en_o), 0);
    for (int i = 0; i < 10; i++) step(i[0], 1'b0, 1'b1);
    check(en_o == 1'b0, "R2 alternating pulses", int'(en_o), 0);
    check(dat_o == 1'b1, "R9 closed idle level", int'(dat_o), 1);

    // R3: qualified opening
    step(0, 0, 1); step(1, 0, 1); step(1, 0, 1); step(0, 0, 1);
    check(en_o == 1'b1, "R3 open after qualification", int'(en_o), 1);
    for (int i = 0; i < 8; i++) begin
      step(0, i[0] ^ i[1], 1);
      check(dat_o == dat, "R4 passthrough", int'(dat_o), int'(dat));
    end
    step(0, 0, 1);

    // R10: a high run one short of the limit keeps the path open
    for (int i = 0; i < IDL - 1; i++) step(0, 1, 1);
    step(0, 0, 1);
    check(en_o == 1'b1 && dat_o == 1'b0, "R10 near-idle run stays open", int'({en_o, dat_o}), 2);

    // R5/R6: idle close, then the window holds the path shut under squelch activity
    for (int i = 0; i < IDL; i++) step(0, 1, 1);
    for (int k = 1; k <= REJ + 3; k++) begin
      step(1, 0, 1);
      if (k == 1) check(en_o == 1'b0 && dat_o == 1'b1, "R5 idle close", int'({en_o, dat_o}), 1);
      if (k == 3) check(en_o == 1'b0, "R6 window ignores squelch", int'(en_o), 0);
      if (k == REJ + 2) check(en_o == 1'b0, "R6 window plus requalify", int'(en_o), 0);
      if (k == REJ + 3) check(en_o == 1'b1, "R6 reopen after window", int'(en_o), 1);
    end

    // R7: DC loss closes without a window
    step(0, 0, 0);
    step(1, 0, 1);
    check(en_o == 1'b0, "R7 DC loss close", int'(en_o), 0);
    step(1, 0, 1);
    step(0, 0, 1);
    check(en_o == 1'b1, "R7 no window after DC loss", int'(en_o), 1);

    // R8: idle close and DC loss on the same edge
    for (int i = 0; i < IDL - 1; i++) step(0, 1, 1);
    step(0, 1, 0);
    for (int k = 1; k <= REJ + 3; k++) begin
      step(1, 0, 1);
      if (k == 3) check(en_o == 1'b0, "R8 idle wins over DC loss", int'(en_o), 0);
      if (k == REJ + 3) check(en_o == 1'b1, "R8 reopen after window", int'(en_o), 1);
    end

    // R1: reset while open
    step(0, 0, 1);
    @(negedge clk); rst_n = 1'b0; #1;
    check(en_o == 1'b0 && dat_o == 1'b1, "R1 reset while open", int'({en_o, dat_o}), 1);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule